// File: doc/BRIEF.md
# NAND Host Command and Address Sequencer

This block sits on the host side of an 8-bit asynchronous NAND bus and issues one operation per request. An operation starts with a first command byte. Column and/or row address bytes follow, and an optional second (confirm) command byte closes it. The block drives chip enable, command latch, address latch, write strobe and the data lines. It then watches the device's ready/busy line until the device reports ready again, or until a cycle limit expires.

A request arrives as a one-cycle `start` pulse. It carries both command bytes and an address-mode field. It also carries a column address, a block number and a page number. The block packs block and page into one row address. It then sends the address bytes in the order the device expects. Each write strobe has a low phase and a high phase whose lengths are set by parameter. The byte and latch levels stay constant through both phases, so they are stable when the device latches on the rising edge.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset and while idle: `ce_n`=1, `we_n`=1, `cle`=0, `ale`=0, `dq_oe`=0, `dq_out`=0, `busy`=0, `done`=0, `timeout`=0.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse during an operation has no effect on any output of that operation.
- R3: Bus cycles go in this order: first command, column bytes, row bytes, then confirm command. `addr_mode` bit 0 enables the COL_CYCLES column bytes, and bit 1 enables the ROW_CYCLES row bytes. `use_confirm`=1 appends `cmd_confirm`.
- R4: Each address group is sent least significant byte first, and every address cycle carries exactly 8 bits. Column byte k is `col_addr[8k+7:8k]`.
- R5: The row address equals `block` shifted left by PAGE_BITS, ORed with `page`, and zero-extended to ROW_CYCLES*8 bits.
- R6: `cle`=1 exactly during command cycles and `ale`=1 exactly during address cycles. The two are never 1 together, and `dq_oe`=1 during both kinds of cycle.
- R7: Each bus cycle holds `we_n` low for WE_LOW clocks and then high for WE_HIGH clocks. `dq_out`, `cle` and `ale` do not change across the rising edge of `we_n`.
- R8: `ce_n` is 0 from the first bus cycle until the ready/busy wait ends. It is 1 in the completion cycle and while idle.
- R9: After the last bus cycle the block idles the bus for BUSY_DELAY clocks. It then samples `rb_n` through a two-flop synchroniser. `done` rises in the cycle after a synchronised high is seen, and `timeout` is 0 in that cycle.
- R10: If the synchronised `rb_n` is low for TIMEOUT_CYCLES consecutive wait cycles, `done` and `timeout` are both 1 in the next cycle.
- R11: `done` lasts exactly one cycle and `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request pulse |
| cmd_first | input | 8 | First command byte |
| cmd_confirm | input | 8 | Confirm command byte |
| use_confirm | input | 1 | Send the confirm command |
| addr_mode | input | 2 | Bit 0: column bytes, bit 1: row bytes |
| col_addr | input | COL_CYCLES*8 | Column address |
| block | input | BLOCK_BITS | Block number |
| page | input | PAGE_BITS | Page number inside the block |
| rb_n | input | 1 | Device ready (1) / busy (0) |
| ce_n | output | 1 | Chip enable, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| we_n | output | 1 | Write strobe, active low |
| dq_out | output | 8 | Byte driven on the bus |
| dq_oe | output | 1 | Bus output enable |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Ready wait expired (valid with done) |

## Verification
The bench builds the block with WE_LOW=2 and WE_HIGH=3, so that unequal strobe phases are visible. It uses BUSY_DELAY=2, two column and three row cycles, PAGE_BITS=6 and BLOCK_BITS=11, so that the block number crosses a byte boundary of the row address. TIMEOUT_CYCLES is set to 40, which keeps the timeout path within a short run. The same limit also lets a device that is busy for a few cycles finish normally. All four address modes are run, with and without the confirm command. The runs also cover an all-ones page, the highest block number, an already-ready device, and a stray start during an operation.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE = 3'd0,
    SQ_BUS  = 3'd1,
    SQ_GAP  = 3'd2,
    SQ_WAIT = 3'd3,
    SQ_DONE = 3'd4
  } seq_state_t;
endpackage

// File: rtl/nand_addr_pack.sv
module nand_addr_pack #(
  parameter int COL_CYCLES = 2,
  parameter int ROW_CYCLES = 3,
  parameter int PAGE_BITS  = 6,
  parameter int BLOCK_BITS = 11,
  parameter int IDX_W      = 3
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              cmd_a,
  input  logic [7:0]              cmd_b,
  input  logic                    with_b,
  input  logic [1:0]              mode,
  input  logic [COL_CYCLES*8-1:0] col,
  input  logic [BLOCK_BITS-1:0]   blk,
  input  logic [PAGE_BITS-1:0]    pg,
  output logic [7:0]              bus_byte,
  output logic                    is_cmd,
  output logic                    is_addr,
  output logic                    is_last
);
  localparam int ROW_W = ROW_CYCLES * 8;

  logic [IDX_W-1:0] n_col, n_row, last_idx;
  logic [ROW_W-1:0] row;

  always_comb begin
    n_col    = mode[0] ? IDX_W'(COL_CYCLES) : '0;
    n_row    = mode[1] ? IDX_W'(ROW_CYCLES) : '0;
    last_idx = n_col + n_row + (with_b ? IDX_W'(1) : '0);
    row      = '0;
    row[PAGE_BITS-1:0]             = pg;
    row[PAGE_BITS +: BLOCK_BITS]   = blk;
    is_cmd   = 1'b0;
    is_addr  = 1'b0;
    bus_byte = 8'h00;
    if (idx == '0) begin
      is_cmd   = 1'b1;
      bus_byte = cmd_a;
    end else if (idx <= n_col) begin
      is_addr  = 1'b1;
      bus_byte = 8'(col >> (8 * (idx - IDX_W'(1))));
    end else if (idx <= n_col + n_row) begin
      is_addr  = 1'b1;
      bus_byte = 8'(row >> (8 * (idx - IDX_W'(1) - n_col)));
    end else begin
      is_cmd   = 1'b1;
      bus_byte = cmd_b;
    end
    is_last = (idx == last_idx);
  end
endmodule

// File: rtl/nand_we_timer.sv
module nand_we_timer #(
  parameter int WE_LOW  = 2,
  parameter int WE_HIGH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic strobe_low,
  output logic cycle_end
);
  localparam int MAXP = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
  localparam int CW   = $clog2(MAXP + 1);

  logic          phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (clear) begin
      phase_d = 1'b0;
      cnt_d   = '0;
    end else if (run) begin
      if (!phase_q && cnt_q == CW'(WE_LOW - 1)) begin
        phase_d = 1'b1;
        cnt_d   = '0;
      end else if (phase_q && cnt_q == CW'(WE_HIGH - 1)) begin
        phase_d = 1'b0;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign strobe_low = !phase_q;
  assign cycle_end  = run && phase_q && (cnt_q == CW'(WE_HIGH - 1));
endmodule

// File: rtl/nand_rb_watch.sv
module nand_rb_watch #(
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n,
  input  logic arm,
  output logic ready,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic          s1_q, s2_q;
  logic [TW-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rb_n;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    if (!arm)
      cnt_d = '0;
    else if (cnt_q == TW'(TIMEOUT_CYCLES - 1))
      cnt_d = cnt_q;
    else
      cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ready   = s2_q;
  assign expired = arm && !s2_q && (cnt_q == TW'(TIMEOUT_CYCLES - 1));
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int COL_CYCLES     = 2,
  parameter int ROW_CYCLES     = 3,
  parameter int PAGE_BITS      = 6,
  parameter int BLOCK_BITS     = 11,
  parameter int WE_LOW         = 2,
  parameter int WE_HIGH        = 2,
  parameter int BUSY_DELAY     = 2,
  parameter int TIMEOUT_CYCLES = 100000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [7:0]              cmd_first,
  input  logic [7:0]              cmd_confirm,
  input  logic                    use_confirm,
  input  logic [1:0]              addr_mode,
  input  logic [COL_CYCLES*8-1:0] col_addr,
  input  logic [BLOCK_BITS-1:0]   block,
  input  logic [PAGE_BITS-1:0]    page,
  input  logic                    rb_n,
  output logic                    ce_n,
  output logic                    cle,
  output logic                    ale,
  output logic                    we_n,
  output logic [7:0]              dq_out,
  output logic                    dq_oe,
  output logic                    busy,
  output logic                    done,
  output logic                    timeout
);
  localparam int COL_W     = COL_CYCLES * 8;
  localparam int MAX_ITEMS = 2 + COL_CYCLES + ROW_CYCLES;
  localparam int IDX_W     = $clog2(MAX_ITEMS + 1);
  localparam int GW        = $clog2(BUSY_DELAY + 1);

  seq_state_t state_q, state_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [GW-1:0]         gcnt_q, gcnt_d;
  logic                  tflag_q, tflag_d;
  logic [7:0]            cmd_a_q, cmd_b_q;
  logic                  with_b_q;
  logic [1:0]            mode_q;
  logic [COL_W-1:0]      col_q;
  logic [BLOCK_BITS-1:0] blk_q;
  logic [PAGE_BITS-1:0]  pg_q;

  logic       accept;
  logic [7:0] item_byte;
  logic       item_cmd, item_addr, item_last;
  logic       strobe_low, cycle_end;
  logic       rb_ready, rb_expired;

  assign accept = start && (state_q == SQ_IDLE);

  nand_addr_pack #(
    .COL_CYCLES(COL_CYCLES), .ROW_CYCLES(ROW_CYCLES),
    .PAGE_BITS(PAGE_BITS), .BLOCK_BITS(BLOCK_BITS), .IDX_W(IDX_W)
  ) u_pack (
    .idx(idx_q), .cmd_a(cmd_a_q), .cmd_b(cmd_b_q), .with_b(with_b_q),
    .mode(mode_q), .col(col_q), .blk(blk_q), .pg(pg_q),
    .bus_byte(item_byte), .is_cmd(item_cmd), .is_addr(item_addr),
    .is_last(item_last)
  );

  nand_we_timer #(.WE_LOW(WE_LOW), .WE_HIGH(WE_HIGH)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept),
    .run(state_q == SQ_BUS), .strobe_low(strobe_low), .cycle_end(cycle_end)
  );

  nand_rb_watch #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_rb (
    .clk(clk), .rst_n(rst_n), .rb_n(rb_n), .arm(state_q == SQ_WAIT),
    .ready(rb_ready), .expired(rb_expired)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    gcnt_d  = '0;
    tflag_d = tflag_q;
    unique case (state_q)
      SQ_IDLE: if (accept) begin
        state_d = SQ_BUS;
        idx_d   = '0;
        tflag_d = 1'b0;
      end
      SQ_BUS: if (cycle_end) begin
        if (item_last) state_d = SQ_GAP;
        else           idx_d   = idx_q + IDX_W'(1);
      end
      SQ_GAP: begin
        if (gcnt_q == GW'(BUSY_DELAY - 1)) state_d = SQ_WAIT;
        else                               gcnt_d  = gcnt_q + GW'(1);
      end
      SQ_WAIT: begin
        if (rb_ready) begin
          state_d = SQ_DONE;
          tflag_d = 1'b0;
        end else if (rb_expired) begin
          state_d = SQ_DONE;
          tflag_d = 1'b1;
        end
      end
      SQ_DONE: state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      gcnt_q  <= '0;
      tflag_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      gcnt_q  <= gcnt_d;
      tflag_q <= tflag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_a_q  <= '0;
      cmd_b_q  <= '0;
      with_b_q <= 1'b0;
      mode_q   <= '0;
      col_q    <= '0;
      blk_q    <= '0;
      pg_q     <= '0;
    end else if (accept) begin
      cmd_a_q  <= cmd_first;
      cmd_b_q  <= cmd_confirm;
      with_b_q <= use_confirm;
      mode_q   <= addr_mode;
      col_q    <= col_addr;
      blk_q    <= block;
      pg_q     <= page;
    end
  end

  always_comb begin
    ce_n    = 1'b1;
    cle     = 1'b0;
    ale     = 1'b0;
    we_n    = 1'b1;
    dq_out  = 8'h00;
    dq_oe   = 1'b0;
    busy    = (state_q != SQ_IDLE);
    done    = (state_q == SQ_DONE);
    timeout = (state_q == SQ_DONE) && tflag_q;
    unique case (state_q)
      SQ_BUS: begin
        ce_n   = 1'b0;
        cle    = item_cmd;
        ale    = item_addr;
        we_n   = !strobe_low;
        dq_out = item_byte;
        dq_oe  = 1'b1;
      end
      SQ_GAP, SQ_WAIT: ce_n = 1'b0;
      default: ;
    endcase
  end
endmodule

// File: rtl/nand_cmd_seq_checks.sv
module nand_cmd_seq_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       cle,
  input logic       ale,
  input logic       we_n,
  input logic [7:0] dq_out,
  input logic       dq_oe,
  input logic       busy,
  input logic       done,
  input logic       timeout
);
  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  p_oe_in_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cle || ale) |-> dq_oe);

  p_stable_at_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> ($stable(dq_out) && $stable(cle) && $stable(ale)));

  p_ce_with_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  p_ce_high_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ce_n);

  p_timeout_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ce_n && we_n && !dq_oe));
endmodule

bind nand_cmd_seq nand_cmd_seq_checks u_checks (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
  .we_n(we_n), .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy),
  .done(done), .timeout(timeout)
);

// File: tb/nand_cmd_seq_test.sv
module nand_cmd_seq_test;
  localparam int COLC = 2, ROWC = 3, PB = 6, BB = 11;
  localparam int WL = 2, WH = 3, BD = 2, TO = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd_first = '0, cmd_confirm = '0;
  logic use_confirm = 1'b0;
  logic [1:0] addr_mode = '0;
  logic [COLC*8-1:0] col_addr = '0;
  logic [BB-1:0] block = '0;
  logic [PB-1:0] page = '0;
  logic rb_n = 1'b1;
  logic ce_n, cle, ale, we_n, dq_oe, busy, done, timeout;
  logic [7:0] dq_out;

  always #10 clk = ~clk;

  nand_cmd_seq #(
    .COL_CYCLES(COLC), .ROW_CYCLES(ROWC), .PAGE_BITS(PB), .BLOCK_BITS(BB),
    .WE_LOW(WL), .WE_HIGH(WH), .BUSY_DELAY(BD), .TIMEOUT_CYCLES(TO)
  ) uut (.*);

  int checks = 0, fails = 0, cycles = 0;

  // reference model: 0 idle, 1 bus/gap queue, 2 waiting, 3 done
  int m_mode = 0, m_wcnt = 0;
  bit m_tflag = 0, m_s1 = 1, m_s2 = 1;
  logic [11:0] q[$]; // {oe, we_n, cle, ale, dq[7:0]}

  task automatic push_item(input logic [7:0] b, input bit c, input bit a);
    for (int i = 0; i < WL; i++) q.push_back({1'b1, 1'b0, c, a, b});
    for (int i = 0; i < WH; i++) q.push_back({1'b1, 1'b1, c, a, b});
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_s1 = 1; m_s2 = 1; q.delete();
    end else begin
      cycles++;
      case (m_mode)
        0: if (start) begin
          longint rowv;
          q.delete();
          push_item(cmd_first, 1, 0);
          if (addr_mode[0])
            for (int k = 0; k < COLC; k++) push_item(8'(col_addr >> (8*k)), 0, 1);
          rowv = (longint'(block) << PB) | longint'(page);
          if (addr_mode[1])
            for (int k = 0; k < ROWC; k++) push_item(8'(rowv >> (8*k)), 0, 1);
          if (use_confirm) push_item(cmd_confirm, 1, 0);
          for (int i = 0; i < BD; i++) q.push_back(12'h400);
          m_mode = 1;
        end
        1: begin
          void'(q.pop_front());
          if (q.size() == 0) begin m_mode = 2; m_wcnt = 0; end
        end
        2: begin
          if (m_s2) begin m_mode = 3; m_tflag = 0; end
          else if (m_wcnt == TO-1) begin m_mode = 3; m_tflag = 1; end
          else m_wcnt++;
        end
        default: m_mode = 0;
      endcase
      m_s2 = m_s1; m_s1 = rb_n;
    end
  end

  task automatic fail_line(input string req, input string what, input int act, input int exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cycles);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic e_ce, e_we, e_cle, e_ale, e_oe, e_busy, e_done, e_to;
      logic [7:0] e_dq;
      e_ce = 1; e_we = 1; e_cle = 0; e_ale = 0; e_oe = 0; e_dq = 0;
      e_busy = (m_mode != 0); e_done = (m_mode == 3); e_to = (m_mode == 3) && m_tflag;
      if (m_mode == 1) begin
        e_ce = 0; {e_oe, e_we, e_cle, e_ale, e_dq} = q[0];
      end else if (m_mode == 2) e_ce = 0;
      checks++;
      if (ce_n !== e_ce) fail_line("R8", "ce_n", ce_n, e_ce);
      else if (we_n !== e_we) fail_line("R7", "we_n", we_n, e_we);
      else if (cle !== e_cle || ale !== e_ale) fail_line("R6", "cle/ale", {cle, ale}, {e_cle, e_ale});
      else if (dq_oe !== e_oe) fail_line("R6", "dq_oe", dq_oe, e_oe);
      else if (dq_out !== e_dq) fail_line("R3 R4 R5", "dq_out", dq_out, e_dq);
      else if (busy !== e_busy) fail_line("R2 R11", "busy", busy, e_busy);
      else if (done !== e_done) fail_line("R9", "done", done, e_done);
      else if (timeout !== e_to) fail_line("R10", "timeout", timeout, e_to);
      else if (cycles > 150000) begin
        fail_line("R9", "watchdog", cycles, 150000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  // busy_len: wait cycles with rb_n low after bus phase; stray: inject start mid-op
  task automatic run_op(input logic [7:0] c1, input logic [7:0] c2, input bit cf,
                        input logic [1:0] md, input logic [COLC*8-1:0] ca,
                        input logic [BB-1:0] bk, input logic [PB-1:0] pg,
                        input int busy_len, input bit stray);
    @(negedge clk);
    cmd_first = c1; cmd_confirm = c2; use_confirm = cf; addr_mode = md;
    col_addr = ca; block = bk; page = pg; rb_n = (busy_len == 0); start = 1;
    @(negedge clk);
    start = 0;
    if (stray) begin // R2: a start while busy must not disturb the operation
      repeat (3) @(negedge clk);
      cmd_first = 8'hFF; addr_mode = 2'b00; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (m_mode == 1) @(negedge clk);
    repeat (busy_len) @(negedge clk);
    rb_n = 1;
    while (m_mode != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({ce_n, we_n, cle, ale, dq_oe, busy, done, timeout} !== 8'b11000000 || dq_out !== 8'h00)
      fail_line("R1", "reset outputs", {ce_n, we_n, cle, ale, dq_oe, busy, done, timeout}, 8'hC0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_op(8'h80, 8'h10, 1, 2'b11, 16'hA55A, 11'h5C3, 6'h2D, 6, 1);   // R3 R4 full op, R2 stray
    run_op(8'h60, 8'hD0, 1, 2'b10, 16'h0000, 11'h7FF, 6'h00, 12, 0);  // R5 row only, top block
    run_op(8'h05, 8'hE0, 1, 2'b01, 16'h1234, 11'h000, 6'h00, 3, 0);   // R4 column only
    run_op(8'h00, 8'h30, 1, 2'b11, 16'hFFFF, 11'h000, 6'h3F, 0, 0);   // R5 page all ones, R9 ready
    run_op(8'hFF, 8'h00, 0, 2'b00, 16'h0000, 11'h000, 6'h00, 2, 0);   // R3 command only
    run_op(8'h70, 8'h00, 0, 2'b01, 16'h00C4, 11'h001, 6'h01, 100, 0); // R10 timeout
    run_op(8'h90, 8'h00, 0, 2'b10, 16'h0000, 11'h400, 6'h15, TO-4, 0); // R9 just inside limit
    repeat (4) @(negedge clk);
    // R11: back to idle after completion
    checks++;
    if (busy !== 1'b0 || done !== 1'b0) fail_line("R11", "busy/done", {busy, done}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule